// File: doc/BRIEF.md
# Byte-Enabled Streaming CRC-32 Engine

This block computes a CRC-32 over a byte stream that arrives as 32-bit words, one word per clock. A valid input acts as a clock enable. While it is high, the engine folds one to four bytes of the current word into a running checksum register. While it is low, the engine is frozen. A two-bit count selects how many bytes of the word take part in the update. This lets a frame end on a partial word. The count can also be tied to a constant so that a narrower stream can be served.

The running register holds the raw checksum. The output word is a formatted copy of that register: within each byte the bit order is reversed, and then every bit is inverted. Many link protocols append the checksum in this form. The checksum of a frame is the output value one cycle after the frame's last bytes are applied with valid high. A synchronous reset starts a new frame.

Top module: `crc32_stream`

## Requirements
- R1: On a rising clock edge where `rst` is low and `in_vld` is high, the raw register takes the CRC of the selected bytes of `in_data`, folded into its previous value. `crc_out` shows the new value from that edge on, so it appears one cycle after the data is applied.
- R2: On an edge where `rst` is low and `in_vld` is low, the raw register and `crc_out` keep their values, whatever `in_data` and `in_cnt` are.
- R3: `in_cnt` holds the number of valid bytes minus one (0 means 1 byte, 3 means 4 bytes). The valid bytes are the lowest-numbered lanes. Lane 0 is `in_data[31:24]`, lane 1 is `[23:16]`, lane 2 is `[15:8]` and lane 3 is `[7:0]`. They are folded in lane order, and each byte is taken most significant bit first.
- R4: Lanes with a number above `in_cnt` have no effect on the result.
- R5: Byte k of `crc_out` (bits 8k+7 to 8k) is the inverse of byte k of the raw register with its bit order reversed. For example, a raw value of 0x478AA4DA gives 0x1DAEDAA4.
- R6: A rising edge with `rst` high loads 0xFFFFFFFF into the raw register, so `crc_out` reads 0x00000000 afterwards.
- R7: Reset has priority. A word applied with `in_vld` high in a reset cycle is discarded.
- R8: The polynomial is 0x04C11DB7 in non-reflected, shift-left form. After any sequence of words, including stall cycles and a partial last word, `crc_out` equals the formatted bit-serial CRC of the accepted bytes taken in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; loads the initial checksum |
| in_vld | input | 1 | Clock enable for the checksum state |
| in_cnt | input | 2 | Number of valid bytes minus one |
| in_data | input | 32 | Data word; lane 0 is bits [31:24] |
| crc_out | output | 32 | Formatted checksum (bits reversed per byte, then inverted) |

## Verification
The bench targets frames of one to nine bytes and partial final words with random junk in the unused lanes. An engine that took the wrong lanes, or let junk leak in, would produce a checksum that differs from the bit-serial model. Stall cycles are placed inside frames; an engine that ran freely would change the checksum during a stall. A reset asserted together with valid data checks that the data is dropped and does not leak into the new frame. The worked example from R5 is reproduced by driving a computed word after reset, which catches a swapped or uninverted output byte order.

// File: rtl/crc32_stream_pkg.sv
package crc32_stream_pkg;

    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;
    localparam int CRC_BYTES = CRC_W / BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [CRC_BYTES-1:0][BYTE_W-1:0] crc_lanes_t;

    localparam crc_t CRC_POLY_STD = 32'h04C1_1DB7;
    localparam crc_t CRC_SEED_STD = 32'hFFFF_FFFF;

    // one byte folded in, most significant bit first
    function automatic crc_t fold_byte(input crc_t c, input byte_t b, input crc_t poly);
        crc_t r;
        r = c;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            if (r[CRC_W-1] ^ b[i])
                r = {r[CRC_W-2:0], 1'b0} ^ poly;
            else
                r = {r[CRC_W-2:0], 1'b0};
        end
        return r;
    endfunction

    function automatic byte_t mirror_byte(input byte_t b);
        byte_t m;
        for (int i = 0; i < BYTE_W; i++) m[i] = b[BYTE_W-1-i];
        return m;
    endfunction

endpackage

// File: rtl/crc32_byte_stage.sv
module crc32_byte_stage
    import crc32_stream_pkg::*;
#(
    parameter crc_t POLY = CRC_POLY_STD
) (
    input  crc_t  crc_i,
    input  byte_t byte_i,
    output crc_t  crc_o
);
    always_comb crc_o = fold_byte(crc_i, byte_i, POLY);
endmodule

// File: rtl/crc32_lane_chain.sv
module crc32_lane_chain
    import crc32_stream_pkg::*;
#(
    parameter int   LANES = 4,
    parameter crc_t POLY  = CRC_POLY_STD,
    localparam int  CNT_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int  DATA_W = LANES * BYTE_W
) (
    input  crc_t              crc_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output crc_t              crc_o
);
    crc_t taps [LANES+1];

    assign taps[0] = crc_i;

    for (genvar k = 0; k < LANES; k++) begin : g_stage
        crc32_byte_stage #(.POLY(POLY)) u_stage (
            .crc_i  (taps[k]),
            .byte_i (data_i[DATA_W-1-k*BYTE_W -: BYTE_W]),
            .crc_o  (taps[k+1])
        );
    end

    // pick the tap after cnt_i+1 bytes; later lanes never reach it
    always_comb begin
        crc_o = taps[LANES];
        for (int k = 0; k < LANES; k++)
            if (int'(cnt_i) == k) crc_o = taps[k+1];
    end
endmodule

// File: rtl/crc32_out_format.sv
module crc32_out_format
    import crc32_stream_pkg::*;
(
    input  crc_t raw_i,
    output crc_t fmt_o
);
    crc_lanes_t raw_l, fmt_l;

    assign raw_l = raw_i;

    for (genvar j = 0; j < CRC_BYTES; j++) begin : g_lane
        assign fmt_l[j] = ~mirror_byte(raw_l[j]);
    end

    assign fmt_o = fmt_l;
endmodule

// File: rtl/crc32_stream.sv
module crc32_stream
    import crc32_stream_pkg::*;
#(
    parameter int   LANES = 4,
    parameter crc_t POLY  = CRC_POLY_STD,
    parameter crc_t SEED  = CRC_SEED_STD,
    localparam int  CNT_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int  DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [CNT_W-1:0]  in_cnt,
    input  logic [DATA_W-1:0] in_data,
    output logic [CRC_W-1:0]  crc_out
);
    crc_t crc_q;
    crc_t crc_nxt;

    crc32_lane_chain #(.LANES(LANES), .POLY(POLY)) u_chain (
        .crc_i  (crc_q),
        .data_i (in_data),
        .cnt_i  (in_cnt),
        .crc_o  (crc_nxt)
    );

    // reset first, then valid acts as the enable
    always_ff @(posedge clk) begin
        if (rst)
            crc_q <= SEED;
        else if (in_vld)
            crc_q <= crc_nxt;
    end

    crc32_out_format u_fmt (
        .raw_i (crc_q),
        .fmt_o (crc_out)
    );
endmodule

// File: rtl/crc32_stream_chk.sv
module crc32_stream_chk
    import crc32_stream_pkg::*;
#(
    parameter crc_t SEED = CRC_SEED_STD
) (
    input logic clk,
    input logic rst,
    input logic in_vld,
    input crc_t crc_q,
    input crc_t crc_nxt,
    input crc_t crc_out
);
    // R6 R7
    reset_load_chk: assert property (@(posedge clk) rst |=> crc_q == SEED);

    // R1
    update_take_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> crc_q == $past(crc_nxt));

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(crc_q) && $stable(crc_out));

    // R5
    out_invert_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(crc_out) == CRC_W - $countones(crc_q));
endmodule

bind crc32_stream crc32_stream_chk #(.SEED(SEED)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .crc_q   (crc_q),
    .crc_nxt (crc_nxt),
    .crc_out (crc_out)
);

// File: tb/crc32_stream_test.sv
module crc32_stream_test;
    localparam logic [31:0] P = 32'h04C1_1DB7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [1:0]  in_cnt = 2'd0;
    logic [31:0] in_data = '0;
    logic [31:0] crc_out;

    int vectors = 0;
    int errs = 0;
    bit done = 0;
    logic [31:0] model = 32'hFFFF_FFFF;

    always #4 clk = ~clk;

    crc32_stream uut (
        .clk(clk), .rst(rst), .in_vld(in_vld),
        .in_cnt(in_cnt), .in_data(in_data), .crc_out(crc_out)
    );

    function automatic logic [31:0] ser_bit(input logic [31:0] c, input logic b);
        logic fb;
        fb = c[31] ^ b;
        return {c[30:0], 1'b0} ^ (fb ? P : 32'h0);
    endfunction

    function automatic logic [31:0] ser_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) r = ser_bit(r, b[i]);
        return r;
    endfunction

    // undo one zero-bit step
    function automatic logic [31:0] unstep(input logic [31:0] c);
        logic [31:0] p;
        p = c ^ (c[0] ? P : 32'h0);
        return {c[0], p[31:1]};
    endfunction

    function automatic logic [31:0] shape(input logic [31:0] r);
        logic [31:0] o;
        for (int k = 0; k < 4; k++)
            for (int j = 0; j < 8; j++)
                o[8*k+j] = ~r[8*k+7-j];
        return o;
    endfunction

    task automatic check(input string tag, input logic [31:0] exp);
        vectors++;
        if (crc_out !== exp) begin
            errs++;
            $display("FAIL %s: crc_out=%08h expected %08h", tag, crc_out, exp);
        end
    endtask

    // drive one cycle, update the model, sample after the edge
    task automatic cycle(input logic r, input logic v, input logic [1:0] c,
                         input logic [31:0] d, input string tag);
        @(negedge clk);
        rst = r; in_vld = v; in_cnt = c; in_data = d;
        @(posedge clk);
        if (r) model = 32'hFFFF_FFFF;
        else if (v)
            for (int k = 0; k <= int'(c); k++)
                model = ser_byte(model, d[31-8*k -: 8]);
        #1;
        check(tag, shape(model));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: crc_out=%08h expected completion", crc_out);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        logic [31:0] x;
        void'($urandom(32'd20240611));

        // R6: reset state
        cycle(1, 0, 2'd0, 32'h0, "R6 reset");
        check("R6 reset value", 32'h0000_0000);

        // R3 R8: known single-word CRC of 00 00 00 01 from seed
        cycle(0, 1, 2'd3, 32'h0000_0001, "R1 R8 full word");

        // R7: reset together with valid data discards the data
        cycle(1, 1, 2'd3, 32'hDEAD_BEEF, "R7 reset priority");
        check("R7 reset priority", 32'h0000_0000);

        // R5: worked example, drive the word that yields raw 478AA4DA
        x = 32'h478A_A4DA;
        for (int i = 0; i < 32; i++) x = unstep(x);
        cycle(0, 1, 2'd3, x ^ 32'hFFFF_FFFF, "R5 worked example model");
        check("R5 worked example", 32'h1DAE_DAA4);

        // R2: stall with changing inputs
        for (int i = 0; i < 4; i++)
            cycle(0, 0, 2'($urandom), $urandom, "R2 stall hold");

        // R3 R4: single byte with junk lanes vs. junk-free
        cycle(1, 0, 2'd0, 32'h0, "R6 reset");
        cycle(0, 1, 2'd0, 32'hA5FF_FFFF, "R4 junk lanes ignored");
        x = crc_out;
        cycle(1, 0, 2'd0, 32'h0, "R6 reset");
        cycle(0, 1, 2'd0, 32'hA500_0000, "R3 single lane");
        check("R4 same result without junk", x);

        // R8: frames of 1..9 bytes with stalls and partial last words
        for (int len = 1; len <= 9; len++) begin
            int left;
            cycle(1, 0, 2'd0, 32'h0, "R6 frame reset");
            left = len;
            while (left > 0) begin
                int n;
                n = (left > 4) ? 4 : left;
                if ($urandom_range(0, 2) == 0)
                    cycle(0, 0, 2'($urandom), $urandom, "R2 stall in frame");
                cycle(0, 1, 2'(n - 1), $urandom,
                      (n < 4) ? "R3 R4 partial word" : "R8 full word");
                left -= n;
            end
        end

        // random mix
        for (int f = 0; f < 400; f++) begin
            int words;
            cycle(1, $urandom_range(0, 1), 2'($urandom), $urandom, "R7 frame reset");
            words = $urandom_range(1, 8);
            for (int w = 0; w < words; w++) begin
                if ($urandom_range(0, 3) == 0)
                    cycle(0, 0, 2'($urandom), $urandom, "R2 random stall");
                cycle(0, 1, (w == words - 1) ? 2'($urandom) : 2'd3, $urandom,
                      "R1 R8 random word");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule